// File: doc/BRIEF.md
# Error-Filtering Receive Byte Buffer

This block sits between a serial receiver and whatever consumes its bytes. In any cycle the receiver may offer one byte, along with four status flags: overrun, parity error, framing error and break. A byte that carries any flag is dropped. Parity, framing and overrun errors are each tallied in their own saturating counter. Clean bytes go into a circular store that holds up to `DEPTH` bytes. A clean byte that arrives while the store is full is discarded and counts toward nothing.

The consumer drains the store through a valid/ready byte stream in arrival order. The block always shows how many bytes are waiting. One cycle after a run of offered bytes ends, it raises a single-cycle notice so the consumer knows a batch has landed.

The store has `DEPTH+1` cells and always keeps one of them unused. The write and read indices are therefore enough to tell full from empty, and no extra state is needed for that.

Top module: `rx_err_filter_buf`

## Requirements
- R1: A byte offered with any of the overrun, parity, framing or break flags set is never stored. The stored count does not rise because of it.
- R2: A parity flag increments `par_errs`, a framing flag increments `frm_errs`, and an overrun flag increments `ovr_errs`. A byte whose only flag is break changes no counter.
- R3: A byte with several flags set increments every matching counter in the same cycle.
- R4: The store holds at most `DEPTH` bytes and delivers them in arrival order. `rd_valid` is high exactly when at least one byte is held. A byte leaves the store when `rd_valid` and `rd_ready` are both high at a clock edge.
- R5: A clean byte offered while `DEPTH` bytes are held is discarded and changes no counter.
- R6: `fill` equals the number of bytes held. This stays true across any wrap of the internal indices, which run from 0 to `DEPTH`.
- R7: `batch_done` is high for exactly one cycle. It rises after the first clock edge at which `in_valid` is low following an edge at which `in_valid` was high. Errored and dropped offers count as arrivals.
- R8: Each counter is `CNT_W` bits wide (default 32) and holds at all ones. `cnt_clr` zeroes all three counters at the next edge and takes priority over any increment in that cycle.
- R9: After reset the store is empty, `fill` is 0, every counter is 0 and `batch_done` is low.
- R10: When the store is full and a read and a clean write happen in the same cycle, the read completes and the write is still rejected, leaving `DEPTH-1` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of the three error counters |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_data | input | 8 | Received byte |
| in_ovr | input | 1 | Overrun flag for the offered byte |
| in_par | input | 1 | Parity error flag |
| in_frm | input | 1 | Framing error flag |
| in_brk | input | 1 | Break flag |
| rd_valid | output | 1 | Store is non-empty; `rd_data` holds the oldest byte |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Oldest stored byte |
| fill | output | $clog2(DEPTH+1) | Number of stored bytes |
| par_errs | output | CNT_W | Parity error count |
| frm_errs | output | CNT_W | Framing error count |
| ovr_errs | output | CNT_W | Overrun error count |
| batch_done | output | 1 | One-cycle notice that a run of arrivals ended |

## Verification
Several properties are checked on every cycle:
- an errored offer never raises the fill level;
- a full store refuses a clean byte;
- a break-only byte leaves the counters alone;
- a saturated counter stays saturated;
- the fill level never exceeds `DEPTH`;
- the batch notice never lasts longer than one cycle.

Other behaviour can only be shown by the bench's scenarios running against a reference queue in a small configuration. This covers arrival-order delivery across many index wraps, the exact counter totals over the full sweep of flag combinations, clear priority, and the read-wins case on a full store.

// File: rtl/rx_err_filter_buf.sv
module rx_err_filter_buf #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  parameter int CNT_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cnt_clr,
  input  logic                       in_valid,
  input  logic [DW-1:0]              in_data,
  input  logic                       in_ovr,
  input  logic                       in_par,
  input  logic                       in_frm,
  input  logic                       in_brk,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic [CNT_W-1:0]           par_errs,
  output logic [CNT_W-1:0]           frm_errs,
  output logic [CNT_W-1:0]           ovr_errs,
  output logic                       batch_done
);
  localparam int CELLS = DEPTH + 1;
  localparam int PW    = $clog2(CELLS);
  localparam logic [PW-1:0] LAST = PW'(DEPTH);

  logic [DW-1:0] mem [CELLS];
  logic [PW-1:0] wp, rp, wp_nx, rp_nx;
  logic          err, full, push, pop, seen;

  assign err      = in_ovr | in_par | in_frm | in_brk;
  assign wp_nx    = (wp == LAST) ? '0 : wp + 1'b1;
  assign rp_nx    = (rp == LAST) ? '0 : rp + 1'b1;
  assign full     = (wp_nx == rp);
  assign rd_valid = (wp != rp);
  assign rd_data  = mem[rp];
  assign push     = in_valid & ~err & ~full;
  assign pop      = rd_valid & rd_ready;
  assign fill     = (wp >= rp) ? wp - rp : wp - rp + PW'(CELLS);

  always_ff @(posedge clk)
    if (push) mem[wp] <= in_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp_nx;
      if (pop)  rp <= rp_nx;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      par_errs <= '0;
      frm_errs <= '0;
      ovr_errs <= '0;
    end else if (cnt_clr) begin
      par_errs <= '0;
      frm_errs <= '0;
      ovr_errs <= '0;
    end else if (in_valid) begin
      if (in_par && par_errs != '1) par_errs <= par_errs + 1'b1;
      if (in_frm && frm_errs != '1) frm_errs <= frm_errs + 1'b1;
      if (in_ovr && ovr_errs != '1) ovr_errs <= ovr_errs + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen       <= 1'b0;
      batch_done <= 1'b0;
    end else begin
      seen       <= in_valid;
      batch_done <= seen & ~in_valid;
    end

  AST_ERR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && err) |=> (fill == $past(fill) - PW'($past(pop)))); // R1
  AST_BREAK_UNCOUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_brk && !in_par && !in_frm && !in_ovr && !cnt_clr)
      |=> ($stable(par_errs) && $stable(frm_errs) && $stable(ovr_errs))); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH)); // R4
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == PW'(DEPTH) && in_valid && !err) |=> (fill == PW'(DEPTH) - PW'($past(pop)))); // R5
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (par_errs == '1 && !cnt_clr) |=> (par_errs == '1)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done |=> !batch_done); // R7
endmodule

// File: tb/rx_err_filter_buf_bench.sv
module rx_err_filter_buf_bench;
  localparam int DEPTH = 4;
  localparam int CNT_W = 4;
  localparam int LW    = $clog2(DEPTH+1);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, cnt_clr = 0, in_valid = 0, rd_ready = 0;
  logic in_ovr = 0, in_par = 0, in_frm = 0, in_brk = 0;
  logic [7:0] in_data = 0, rd_data;
  logic rd_valid, batch_done;
  logic [LW-1:0] fill;
  logic [CNT_W-1:0] par_errs, frm_errs, ovr_errs;

  int checks = 0, errors = 0, cyc = 0;
  int m_par = 0, m_frm = 0, m_ovr = 0, m_pulse = 0, m_seen = 0;
  int snap_p, snap_f, snap_o;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  rx_err_filter_buf #(.DEPTH(DEPTH), .DW(8), .CNT_W(CNT_W)) u_rx_err_filter_buf (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .in_par(in_par), .in_frm(in_frm), .in_brk(in_brk),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .fill(fill),
    .par_errs(par_errs), .frm_errs(frm_errs), .ovr_errs(ovr_errs), .batch_done(batch_done));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // flags = {brk, frm, par, ovr}
  task automatic step(input bit v, input logic [7:0] d, input logic [3:0] flags,
                      input bit rdy, input bit clr);
    bit pop, push;
    logic [7:0] head;
    in_valid = v; in_data = d; rd_ready = rdy; cnt_clr = clr;
    {in_brk, in_frm, in_par, in_ovr} = flags;
    #1;
    chk("R4 rd_valid", rd_valid, q.size() > 0);
    if (q.size() > 0) begin
      head = q[0];
      chk("R4 order", rd_data, head);
    end
    pop  = (q.size() > 0) && rdy;
    push = v && (flags == 0) && (q.size() < DEPTH);
    @(posedge clk); #1;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(d);
    if (clr) begin
      m_par = 0; m_frm = 0; m_ovr = 0;
    end else if (v) begin
      if (flags[1] && m_par < CMAX) m_par++;
      if (flags[2] && m_frm < CMAX) m_frm++;
      if (flags[0] && m_ovr < CMAX) m_ovr++;
    end
    m_pulse = m_seen && !v;
    m_seen  = v;
    chk("R6 fill", fill, q.size());
    chk("R2 par", par_errs, m_par);
    chk("R2 frm", frm_errs, m_frm);
    chk("R2 ovr", ovr_errs, m_ovr);
    chk("R7 pulse", batch_done, m_pulse);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 fill", fill, 0);
    chk("R9 rd_valid", rd_valid, 0);
    chk("R9 counters", par_errs + frm_errs + ovr_errs, 0);
    chk("R9 pulse", batch_done, 0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int f = 1; f < 16; f++) step(1, 8'(f), 4'(f), 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R1 nothing stored", fill, 0);
    chk("R7 pulse after run", batch_done, 1);
    step(0, 0, 0, 0, 0);
    chk("R7 pulse one cycle", batch_done, 0);

    snap_p = par_errs; snap_f = frm_errs; snap_o = ovr_errs;
    step(1, 8'h55, 4'b0111, 0, 0);
    chk("R3 par", par_errs, snap_p + 1);
    chk("R3 frm", frm_errs, snap_f + 1);
    chk("R3 ovr", ovr_errs, snap_o + 1);
    snap_p = par_errs; snap_f = frm_errs; snap_o = ovr_errs;
    step(1, 8'h66, 4'b1000, 0, 0);
    chk("R2 break alone", par_errs + frm_errs + ovr_errs, snap_p + snap_f + snap_o);

    step(0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'(8'hA0 + i), 0, 0, 0);
    chk("R5 full keeps DEPTH", fill, DEPTH);
    chk("R5 no count", par_errs + frm_errs + ovr_errs, 0);
    chk("R4 head is first", rd_data, 8'hA0);

    step(1, 8'hEE, 0, 1, 0);
    chk("R10 read wins", fill, DEPTH - 1);

    for (int i = 0; i < 400; i++)
      step(i % 3 != 2, 8'(i * 7), (i % 7 == 0) ? 4'b0010 : ((i % 11 == 0) ? 4'b0101 : 4'b0000),
           (i % 5) < 2 || (i / 40) % 2 == 1, 0);

    step(0, 0, 0, 0, 1);
    for (int i = 0; i < CMAX + 5; i++) step(1, 8'(i), 4'b0110, 1, 0);
    chk("R8 saturate par", par_errs, CMAX);
    chk("R8 saturate frm", frm_errs, CMAX);
    step(1, 8'h01, 4'b0111, 1, 1);
    chk("R8 clear wins", par_errs + frm_errs + ovr_errs, 0);

    for (int i = 0; i < 2 * DEPTH; i++) step(0, 0, 0, 1, 0);
    chk("R6 drained", fill, 0);
    finish_run();
  end
endmodule